// File: doc/BRIEF.md
# Half-duplex three-wire SPI master

This block is an SPI master for slaves that share a single data wire for both directions. The wire reaches the slave through two external differential buffers. The master steers them with a local direction output and a remote direction output. A value of 1 on either output means that data flows from master to slave. The line itself is presented as a `dataOut` / `dataIn` pair, and `localDir` doubles as the output enable.

The host starts a transfer with a one-cycle command. The command carries the direction (write or read), the word, a word length, a two-bit mode, a half-bit divider, the chip-select active level, a "last transfer" flag and a "next is a read" flag. Several commands can be chained inside one chip-select frame by clearing the last flag. The block inverts data in both directions. When a phase-1 write is followed by a read, it releases the line halfway through the final bit.

Top module: `hdx_spi_master`

## Requirements
- R1: Bits travel most significant first. The effective length L equals `cmdLen`, except that 0 selects 8 and any value above 16 selects 16. A read returns its L bits in the low bits of `rdData`, with all higher bits zero.
- R2: `sclkOut` idles at NOT `cmdMode[1]`, and `cmdMode[0]` selects the phase. After reset, and whenever the block is idle, the clock holds that idle level (1 after reset).
- R3: During a write, bit k of the line (k = 0 first) equals the inverse of word bit L-1-k.
- R4: When a write is accepted, `localDir` and `remoteDir` go to 1 and `csOut` goes to `cmdCsPol` at the same edge. Both direction outputs always carry the same value.
- R5: Each half-bit lasts `cmdDiv` system clocks, and a value of 0 selects 250 clocks. In a phase-1 write, the clock is non-idle from acceptance for the first half of every bit and idle for the second half. The transfer ends after 2·L halves.
- R6: In a phase-0 write, the clock is idle for the first half of every bit and non-idle for the second half.
- R7: In a phase-1 write flagged "next is a read", both direction outputs drop to 0 at the midpoint of the final bit.
- R8: When a read is accepted, the direction outputs go to 0 and chip select is asserted. The clock stays idle for one half-bit. Each bit then has the clock non-idle for its first half and idle for its second half, so the transfer ends after (2·L+1) halves.
- R9: In a phase-0 read, each bit is sampled at the edge where the clock leaves idle. In a phase-1 read, each bit is sampled at the edge where the clock returns to idle. `rdData` holds the inverse of the sampled bits from the done pulse onward.
- R10: A transfer flagged last drives `csOut` to NOT `cmdCsPol` at its end, and a last write also sets both direction outputs to 0.
- R11: A transfer not flagged last keeps chip select asserted at its end and leaves the direction outputs unchanged.
- R12: `busy` is high from the edge after acceptance until the edge where `done` pulses high for one cycle. A command offered while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command strobe, taken when not busy |
| cmdRead | input | 1 | 1 = read, 0 = write |
| cmdWord | input | 16 | Word to write (low L bits used) |
| cmdLen | input | 5 | Word length, 0 = 8 |
| cmdMode | input | 2 | Bit 1 inverts idle level, bit 0 is phase |
| cmdDiv | input | 16 | System clocks per half-bit, 0 = default |
| cmdLast | input | 1 | Release chip select at end |
| cmdNextRd | input | 1 | A read follows this write |
| cmdCsPol | input | 1 | Chip-select active level |
| dataIn | input | 1 | Shared line, received value |
| sclkOut | output | 1 | Serial clock |
| csOut | output | 1 | Chip select |
| dataOut | output | 1 | Shared line, driven value |
| localDir | output | 1 | Local buffer direction, 1 = master drives |
| remoteDir | output | 1 | Remote buffer direction, 1 = master drives |
| rdData | output | 16 | Last read word, inverted |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
A half-bit counter that is off by even one clock shows up at once as a clock edge in the wrong cycle, so the expected waveform is compared at every system clock of every transfer. A bit counter that is wrong moves the done pulse by whole bits, and it also corrupts the bit order the bench reads back. A direction register that flips at the wrong moment shows on `localDir` within the same half-bit. This matters most at the read turnaround and after unflagged transfers. A chip-select or direction state that leaks from one command into the next becomes visible at the boundary of the following transfer.

// File: rtl/hdx_spi_pkg.sv
package hdx_spi_pkg;
  // Strobes from the sequencer to the datapath, valid for one clock.
  typedef struct packed {
    logic load;      // latch a new command
    logic dirOut;    // buffers to master-drives
    logic dirIn;     // buffers to master-listens
    logic csOn;      // assert chip select
    logic csOff;     // release chip select
    logic clkOn;     // serial clock to non-idle
    logic clkOff;    // serial clock to idle
    logic shiftOut;  // advance to next transmit bit
    logic sample;    // capture the line
    logic latchRx;   // publish received word
  } strobe_t;
endpackage

// File: rtl/hdx_spi_ctrl.sv
module hdx_spi_ctrl
  import hdx_spi_pkg::*;
#(
  parameter int LEN_W    = 5,
  parameter int DIV_W    = 16,
  parameter int DEF_HALF = 250
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdRead,
  input  logic             cmdPhase,
  input  logic             cmdLast,
  input  logic             cmdNextRd,
  input  logic [LEN_W-1:0] effLen,
  input  logic [DIV_W-1:0] cmdDiv,
  output strobe_t          strobe,
  output logic             busy,
  output logic             done
);
  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_A, ST_B} state_t;

  state_t           state, nextState;
  logic [DIV_W-1:0] halfCnt, halfMaxR, halfLenIn;
  logic [LEN_W-1:0] bitCnt;
  logic             readR, phaseR, lastR, nextRdR;
  logic             halfEnd, lastBit, finish;

  assign halfLenIn = (cmdDiv == '0) ? DIV_W'(DEF_HALF) : cmdDiv;
  assign halfEnd   = (halfCnt == '0);
  assign lastBit   = (bitCnt == '0);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    strobe    = '0;
    nextState = state;
    finish    = 1'b0;
    unique case (state)
      ST_IDLE: if (cmdValid) begin
        strobe.load = 1'b1;
        strobe.csOn = 1'b1;
        if (cmdRead) begin
          strobe.dirIn = 1'b1;
          nextState    = ST_LEAD;
        end else begin
          strobe.dirOut = 1'b1;
          strobe.clkOn  = cmdPhase;
          nextState     = ST_A;
        end
      end
      ST_LEAD: if (halfEnd) begin
        strobe.clkOn  = 1'b1;
        strobe.sample = !phaseR;
        nextState     = ST_A;
      end
      ST_A: if (halfEnd) begin
        nextState = ST_B;
        if (readR) begin
          strobe.clkOff = 1'b1;
          strobe.sample = phaseR;
        end else if (phaseR) begin
          strobe.clkOff = 1'b1;
          strobe.dirIn  = lastBit && nextRdR;
        end else begin
          strobe.clkOn = 1'b1;
        end
      end
      ST_B: if (halfEnd) begin
        if (lastBit) begin
          finish         = 1'b1;
          strobe.clkOff  = 1'b1;
          strobe.latchRx = readR;
          strobe.csOff   = lastR;
          strobe.dirIn   = lastR && !readR;
          nextState      = ST_IDLE;
        end else begin
          nextState = ST_A;
          if (readR) begin
            strobe.clkOn  = 1'b1;
            strobe.sample = !phaseR;
          end else begin
            strobe.shiftOut = 1'b1;
            strobe.clkOn    = phaseR;
            strobe.clkOff   = !phaseR;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      halfCnt  <= '0;
      halfMaxR <= '0;
      bitCnt   <= '0;
      readR    <= 1'b0;
      phaseR   <= 1'b0;
      lastR    <= 1'b0;
      nextRdR  <= 1'b0;
      done     <= 1'b0;
    end else begin
      state <= nextState;
      done  <= finish;
      if (strobe.load) begin
        halfCnt  <= halfLenIn - 1'b1;
        halfMaxR <= halfLenIn - 1'b1;
        bitCnt   <= effLen - 1'b1;
        readR    <= cmdRead;
        phaseR   <= cmdPhase;
        lastR    <= cmdLast;
        nextRdR  <= cmdNextRd;
      end else if (busy) begin
        halfCnt <= halfEnd ? halfMaxR : halfCnt - 1'b1;
        if (state == ST_B && halfEnd && !lastBit) bitCnt <= bitCnt - 1'b1;
      end
    end
  end

  // R12: done is a single-cycle pulse
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R12: the block is idle whenever done is shown
  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: rtl/hdx_spi_dp.sv
module hdx_spi_dp
  import hdx_spi_pkg::*;
#(
  parameter int MAX_W = 16,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [MAX_W-1:0] cmdWord,
  input  logic [LEN_W-1:0] effLen,
  input  logic             cmdIdleInv,
  input  logic             cmdCsPol,
  input  logic             dataIn,
  output logic             sclkOut,
  output logic             csOut,
  output logic             dataOut,
  output logic             dirOut,
  output logic [MAX_W-1:0] rdData
);
  logic [MAX_W-1:0] txReg, rxReg;
  logic [LEN_W-1:0] lenR;
  logic             clkActive, idleLevel, polR;

  assign sclkOut = clkActive ^ idleLevel;
  assign dataOut = txReg[MAX_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg     <= '0;
      rxReg     <= '0;
      lenR      <= '0;
      clkActive <= 1'b0;
      idleLevel <= 1'b1;
      polR      <= 1'b0;
      csOut     <= 1'b1;
      dirOut    <= 1'b1;
      rdData    <= '0;
    end else begin
      if (strobe.load) begin
        txReg     <= (~cmdWord) << (MAX_W - effLen);
        rxReg     <= '0;
        lenR      <= effLen;
        idleLevel <= ~cmdIdleInv;
      end else begin
        if (strobe.shiftOut) txReg <= {txReg[MAX_W-2:0], 1'b0};
        if (strobe.sample)   rxReg <= {rxReg[MAX_W-2:0], dataIn};
      end
      if (strobe.clkOn) clkActive <= 1'b1;
      else if (strobe.clkOff || strobe.load) clkActive <= 1'b0;
      if (strobe.csOn) begin
        csOut <= cmdCsPol;
        polR  <= cmdCsPol;
      end else if (strobe.csOff) begin
        csOut <= ~polR;
      end
      if (strobe.dirOut) dirOut <= 1'b1;
      else if (strobe.dirIn) dirOut <= 1'b0;
      if (strobe.latchRx)
        rdData <= ~rxReg & ({MAX_W{1'b1}} >> (MAX_W - lenR));
    end
  end

  // R9: the line is only sampled while the buffers face the master
  assert_sample_listening_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sample |-> !dirOut);
  // R3: later write bits are only shifted out while the master drives
  assert_shift_driving_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftOut |-> dirOut);
endmodule

// File: rtl/hdx_spi_master.sv
module hdx_spi_master
  import hdx_spi_pkg::*;
#(
  parameter int MAX_W      = 16,
  parameter int DEF_LEN    = 8,
  parameter int DIV_W      = 16,
  parameter int SYS_CLK_HZ = 250_000_000,
  parameter int SCLK_HZ    = 500_000,
  localparam int LEN_W     = $clog2(MAX_W + 1),
  localparam int DEF_HALF  = SYS_CLK_HZ / (2 * SCLK_HZ)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdRead,
  input  logic [MAX_W-1:0] cmdWord,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic [1:0]       cmdMode,
  input  logic [DIV_W-1:0] cmdDiv,
  input  logic             cmdLast,
  input  logic             cmdNextRd,
  input  logic             cmdCsPol,
  input  logic             dataIn,
  output logic             sclkOut,
  output logic             csOut,
  output logic             dataOut,
  output logic             localDir,
  output logic             remoteDir,
  output logic [MAX_W-1:0] rdData,
  output logic             busy,
  output logic             done
);
  strobe_t          strobe;
  logic [LEN_W-1:0] effLen;
  logic             dirOut;

  assign effLen = (cmdLen == '0) ? LEN_W'(DEF_LEN) :
                  (cmdLen > LEN_W'(MAX_W)) ? LEN_W'(MAX_W) : cmdLen;
  assign localDir  = dirOut;
  assign remoteDir = dirOut;

  hdx_spi_ctrl #(.LEN_W(LEN_W), .DIV_W(DIV_W), .DEF_HALF(DEF_HALF)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdRead(cmdRead),
    .cmdPhase(cmdMode[0]), .cmdLast(cmdLast), .cmdNextRd(cmdNextRd),
    .effLen(effLen), .cmdDiv(cmdDiv), .strobe(strobe), .busy(busy), .done(done)
  );

  hdx_spi_dp #(.MAX_W(MAX_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdWord(cmdWord), .effLen(effLen),
    .cmdIdleInv(cmdMode[1]), .cmdCsPol(cmdCsPol), .dataIn(dataIn),
    .sclkOut(sclkOut), .csOut(csOut), .dataOut(dataOut), .dirOut(dirOut),
    .rdData(rdData)
  );

  // R2: the serial clock does not move while the block is idle
  assert_sclk_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> $stable(sclkOut));
  // R11: chip select cannot change in the middle of a transfer
  assert_cs_steady_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(csOut));
endmodule

// File: tb/hdx_spi_master_tb.sv
`timescale 1ns/1ps
module hdx_spi_master_tb;
  logic        clk = 1'b0, rstN = 1'b0;
  logic        cmdValid = 0, cmdRead = 0, cmdLast = 0, cmdNextRd = 0, cmdCsPol = 0;
  logic        dataIn = 0;
  logic [15:0] cmdWord = '0, cmdDiv = '0;
  logic [4:0]  cmdLen = '0;
  logic [1:0]  cmdMode = '0;
  logic        sclkOut, csOut, dataOut, localDir, remoteDir, busy, done;
  logic [15:0] rdData;
  int          checks = 0, fails = 0;
  bit          finished = 0;

  always #2 clk = ~clk;

  hdx_spi_master u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdRead(cmdRead),
    .cmdWord(cmdWord), .cmdLen(cmdLen), .cmdMode(cmdMode), .cmdDiv(cmdDiv),
    .cmdLast(cmdLast), .cmdNextRd(cmdNextRd), .cmdCsPol(cmdCsPol),
    .dataIn(dataIn), .sclkOut(sclkOut), .csOut(csOut), .dataOut(dataOut),
    .localDir(localDir), .remoteDir(remoteDir), .rdData(rdData),
    .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // One command, checked at every falling edge until one cycle past done.
  task automatic xfer(input bit rd, input logic [15:0] word, input int len,
                      input logic [1:0] mode, input int div, input bit last,
                      input bit nxt, input bit pol, input int glitch);
    int H, L, endN, k;
    bit ph, inA, act, expDir, expCs;
    logic [15:0] inv;
    H = (div == 0) ? 250 : div;
    L = (len == 0) ? 8 : (len > 16 ? 16 : len);
    ph = mode[0];
    endN = rd ? (2*L+1)*H : 2*L*H;
    inv = ~word;
    cmdRead = rd; cmdWord = word; cmdLen = 5'(len); cmdMode = mode;
    cmdDiv = 16'(div); cmdLast = last; cmdNextRd = nxt; cmdCsPol = pol;
    cmdValid = 1;
    @(posedge clk);
    for (int n = 0; n <= endN + 1; n++) begin
      @(negedge clk);
      if (n == 0) cmdValid = 0;
      if (n == glitch) begin
        cmdValid = 1; cmdRead = !rd; cmdWord = ~word; cmdCsPol = !pol; cmdLast = !last;
      end
      if (n == glitch + 1) begin
        cmdValid = 0; cmdRead = rd; cmdWord = word; cmdCsPol = pol; cmdLast = last;
      end
      if (rd) begin
        k = ph ? n/(2*H) : (n+H)/(2*H);
        if (k >= L) k = L-1;
        dataIn = word[L-1-k];
      end else dataIn = 0;
      if (n < endN) begin
        if (rd) begin
          act = (n >= H) && (((n-H) % (2*H)) < H);
          chk("R8 sclk", sclkOut, act ^ !mode[1]);
          chk("R8 dir", localDir, 0);
        end else begin
          k = n/(2*H);
          inA = (n % (2*H)) < H;
          act = ph ? inA : !inA;
          chk(ph ? "R5 sclk" : "R6 sclk", sclkOut, act ^ !mode[1]);
          chk("R1/R3 data", dataOut, inv[L-1-k]);
          expDir = !(ph && nxt && n >= endN - H);
          chk(expDir ? "R4 dir" : "R7 dir", localDir, expDir);
        end
        chk("R4 cs", csOut, pol);
        chk("R12 busy", busy, 1);
        chk("R12 done", done, 0);
      end else begin
        chk("R2 idle sclk", sclkOut, !mode[1]);
        expCs = last ? !pol : pol;
        chk(last ? "R10 cs" : "R11 cs", csOut, expCs);
        if (rd) expDir = 0;
        else if (last) expDir = 0;
        else expDir = !(ph && nxt);
        chk(last ? "R10 dir" : "R11 dir", localDir, expDir);
        chk("R12 busy", busy, 0);
        chk("R12 done", done, n == endN);
        if (rd) chk("R9/R1 rdData", rdData, ~word & (16'hFFFF >> (16-L)));
      end
      chk("R4 remoteDir", remoteDir, localDir);
    end
  endtask

  task automatic testReset();
    chk("R2 reset sclk", sclkOut, 1);
    chk("R10 reset cs", csOut, 1);
    chk("R4 reset dir", localDir, 1);
    chk("R12 reset busy", busy, 0);
    chk("R12 reset done", done, 0);
    chk("R9 reset rdData", rdData, 0);
  endtask

  task automatic testWritePhase1();  xfer(0, 16'h00A5, 8, 2'd1, 3, 1, 0, 0, -5); endtask
  task automatic testWritePhase0();  xfer(0, 16'h03C9, 10, 2'd2, 2, 1, 0, 1, -5); endtask
  task automatic testTurnaround();
    xfer(0, 16'h002D, 6, 2'd3, 3, 0, 1, 0, -5);
    xfer(1, 16'h0015, 6, 2'd3, 3, 1, 0, 0, -5);
  endtask
  task automatic testReadChain();
    xfer(1, 16'h0B3E, 12, 2'd0, 4, 0, 0, 1, -5);
    xfer(1, 16'h0009, 4, 2'd0, 4, 1, 0, 1, -5);
  endtask
  task automatic testWriteHold();
    xfer(0, 16'h0056, 7, 2'd1, 2, 0, 0, 0, -5);
    xfer(0, 16'h0001, 3, 2'd1, 2, 1, 0, 0, -5);
  endtask
  task automatic testDefaults();  xfer(0, 16'h0093, 0, 2'd1, 0, 1, 0, 0, -5); endtask
  task automatic testLenClamp();  xfer(1, 16'hC5A3, 20, 2'd1, 2, 1, 0, 0, -5); endtask
  task automatic testBusyIgnore();
    xfer(0, 16'h006B, 8, 2'd1, 3, 1, 0, 0, 7);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R12 no late start", busy, 0);
    end
  endtask

  initial begin
    #(4.0 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testWritePhase1();
    testWritePhase0();
    testTurnaround();
    testReadChain();
    testWriteHold();
    testDefaults();
    testLenClamp();
    testBusyIgnore();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule